// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block is a register-mapped peripheral holding four independent 32-bit timers. Each timer counts down by one on every pulse of a shared counter-clock enable. When a timer decrements past zero, it reloads from its own programmable reload register. The same step adds one to a 32-bit wrap count and raises a sticky interrupt status bit. One global enable gates all counting. Each timer also has its own local enable, and setting that enable loads the counter from the reload register.

Software reaches the block through a plain 32-bit read/write port with a one-cycle registered read path. Reading a timer's wrap-count register has a side effect: in the same clock edge, the live counter is copied into a held snapshot. The current-value register returns that snapshot. Reading the wrap count first and the current value second therefore yields a pair taken at the same instant. Because the counter runs downward, the elapsed tick count from a reload of all ones is the bitwise inverse of the value read.

Each timer is controlled by a two-state machine. In state CH_OFF (local enable clear) the counter holds. Writing 1 to the config bit causes transition OFF_TO_RUN, which loads the reload value. In state CH_RUN the counter steps on each tick while the global enable is set. Writing 0 to the config bit causes transition RUN_TO_OFF. A wrap in CH_RUN stays in CH_RUN.

Top module: `tmrbank_top`

## Requirements
- R1: After reset, every readable register of every timer reads 0, the global control register reads 0, and `irq_o` is 0.
- R2: Bit 0 of the global control register (offset 0x00) is the global enable. While it is 0, no counter changes on a tick.
- R3: Bit 0 of timer n's config register (offset 0x20+0x20·n) is its local enable. Writing 1 while the enable is clear loads the counter from the reload register (offset +0x04). Writing 0 stops counting, and the counter keeps its value.
- R4: The current-value register (offset +0x08) returns a snapshot. The snapshot changes only on a read of the same timer's wrap-count register, and keeps its value across ticks otherwise.
- R5: On a tick with the counter at 0 in CH_RUN, the counter reloads, the wrap count adds one, and status bit 0 (offset +0x10) is set. After k ticks from a load with reload value V, the counter is V − (k mod (V+1)).
- R6: A read of the wrap-count register (offset +0x0C) returns the count as it stood at that edge, and the snapshot taken at the same edge holds the counter from that instant.
- R7: Writing 1 to bit 0 of the clear register (offset +0x14) clears the status bit. If a wrap happens on the same edge, the status bit stays set. The clear register reads 0.
- R8: `irq_o` is the OR over all timers of status bit 0 AND mask bit 0 (mask register at offset +0x18). A mask of 0 keeps that timer off the interrupt.
- R9: Offset 0x10 reads the constant `REV_ID`. Unmapped or misaligned offsets read 0, and writes to them change nothing.
- R10: Timers are independent. Activity on one timer leaves every other timer's wrap count unchanged.
- R11: With a reload value of 0xFFFFFFFF, the bitwise inverse of the value read equals the number of ticks since the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Shared counter-clock enable; one decrement per high cycle |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The main sweep runs every timer through reload values 0 to 3 and tick counts 0 to 9. This covers sub-period counts, exact multiples and several wraps, and it separates an off-by-one in the reload period from a missing or doubled wrap increment. Directed patterns check the following:
- Ticks with the global enable clear, to show the global gate.
- A local disable in mid-count, to show the counter holds.
- Ticks between two value reads, to show the snapshot only follows wrap-count reads.
- A clear issued on a wrapping edge, to show that set wins.
- The full 32-bit reload, to show the inverse elapsed-time relation.
After each timer's sweep, the other timers' wrap counts are re-read to confirm that the timers are independent.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;

    // Per-timer state: counter held or counter running
    typedef enum logic [0:0] {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;

    // Byte offsets inside the top-level block (block index 0)
    localparam logic [4:0] OFS_GCTRL = 5'h00;
    localparam logic [4:0] OFS_REV   = 5'h10;

    // Byte offsets inside one timer's 0x20-byte block
    localparam logic [4:0] CR_CFG    = 5'h00;
    localparam logic [4:0] CR_RELOAD = 5'h04;
    localparam logic [4:0] CR_VALUE  = 5'h08;
    localparam logic [4:0] CR_OVF    = 5'h0C;
    localparam logic [4:0] CR_STAT   = 5'h10;
    localparam logic [4:0] CR_CLR    = 5'h14;
    localparam logic [4:0] CR_MASK   = 5'h18;

    // Access strobes the decoder hands to one timer
    typedef struct packed {
        logic cfg_wr;
        logic reload_wr;
        logic clr_wr;
        logic mask_wr;
        logic ovf_rd;
    } ch_acc_t;

endpackage

// File: rtl/tmrbank_decode.sv
module tmrbank_decode
    import tmrbank_pkg::*;
#(
    parameter int AW     = 8,
    parameter int NUM_CH = 4,
    localparam int BLK_W = AW - 5
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    output logic             gctrl_wr,
    output logic             rd_en,
    output logic [BLK_W-1:0] blk,
    output logic [4:0]       sub,
    output ch_acc_t          acc_o [NUM_CH]
);

    logic aligned;
    logic wr_ok;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        blk      = bus_addr[AW-1:5];
        sub      = bus_addr[4:0];
        wr_ok    = bus_sel && bus_wr && aligned;
        rd_en    = bus_sel && !bus_wr && aligned;
        gctrl_wr = wr_ok && (blk == '0) && (sub == OFS_GCTRL);
    end

    // Timer n occupies block index n+1 (base 0x20 + 0x20*n)
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        logic hit;
        always_comb begin
            hit                = (blk == BLK_W'(i + 1));
            acc_o[i].cfg_wr    = wr_ok && hit && (sub == CR_CFG);
            acc_o[i].reload_wr = wr_ok && hit && (sub == CR_RELOAD);
            acc_o[i].clr_wr    = wr_ok && hit && (sub == CR_CLR);
            acc_o[i].mask_wr   = wr_ok && hit && (sub == CR_MASK);
            acc_o[i].ovf_rd    = rd_en && hit && (sub == CR_OVF);
        end
    end

endmodule

// File: rtl/tmrbank_chan.sv
module tmrbank_chan
    import tmrbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glob_en,
    input  logic          tick,
    input  ch_acc_t       acc,
    input  logic [DW-1:0] wdata,
    output logic          en_o,
    output logic [DW-1:0] reload_o,
    output logic [DW-1:0] snap_o,
    output logic [DW-1:0] ovf_o,
    output logic          stat_o,
    output logic          mask_o
);

    ch_state_e     st_q, st_d;
    logic          load_evt;
    logic          dec_evt;
    logic          wrap_evt;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] reload_q;
    logic [DW-1:0] snap_q;
    logic [DW-1:0] ovf_q;
    logic          stat_q;
    logic          mask_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // Next state: OFF_TO_RUN on enable set, RUN_TO_OFF on enable clear
    always_comb begin
        st_d     = st_q;
        load_evt = 1'b0;
        unique case (st_q)
            CH_OFF: if (acc.cfg_wr && wdata[0]) begin
                st_d     = CH_RUN;
                load_evt = 1'b1;
            end
            CH_RUN: if (acc.cfg_wr && !wdata[0]) begin
                st_d = CH_OFF;
            end
        endcase
    end

    // State-derived outputs and events
    always_comb begin
        en_o     = (st_q == CH_RUN);
        dec_evt  = (st_q == CH_RUN) && glob_en && tick;
        wrap_evt = dec_evt && (cnt_q == '0);
    end

    // Counter, wrap count and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ovf_q  <= '0;
            snap_q <= '0;
        end else begin
            if (load_evt || wrap_evt) cnt_q <= reload_q;
            else if (dec_evt)         cnt_q <= cnt_q - 1'b1;
            if (wrap_evt)             ovf_q <= ovf_q + 1'b1;
            if (acc.ovf_rd)           snap_q <= cnt_q;
        end
    end

    // Software-written fields and sticky status (set beats clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            stat_q   <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            if (acc.reload_wr)              reload_q <= wdata;
            if (acc.mask_wr)                mask_q   <= wdata[0];
            if (wrap_evt)                   stat_q   <= 1'b1;
            else if (acc.clr_wr && wdata[0]) stat_q  <= 1'b0;
        end
    end

    assign reload_o = reload_q;
    assign snap_o   = snap_q;
    assign ovf_o    = ovf_q;
    assign stat_o   = stat_q;
    assign mask_o   = mask_q;

    // R2
    glob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !load_evt) |=> $stable(cnt_q));

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (cnt_q == $past(reload_q)) && (st_q == CH_RUN));

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.ovf_rd |=> $stable(snap_q));

    // R5
    wrap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (ovf_q == $past(ovf_q) + 1'b1));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> stat_q);

endmodule

// File: rtl/tmrbank_rdmux.sv
module tmrbank_rdmux
    import tmrbank_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          NUM_CH = 4,
    parameter int          BLK_W  = 3,
    parameter logic [31:0] REV_ID = 32'h0002_0001
) (
    input  logic             rd_en,
    input  logic [BLK_W-1:0] blk,
    input  logic [4:0]       sub,
    input  logic             gen_q,
    input  logic             ch_en     [NUM_CH],
    input  logic [DW-1:0]    ch_reload [NUM_CH],
    input  logic [DW-1:0]    ch_snap   [NUM_CH],
    input  logic [DW-1:0]    ch_ovf    [NUM_CH],
    input  logic             ch_stat   [NUM_CH],
    input  logic             ch_mask   [NUM_CH],
    output logic [DW-1:0]    rd_d
);

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            if (blk == '0) begin
                if (sub == OFS_GCTRL)    rd_d = {{(DW-1){1'b0}}, gen_q};
                else if (sub == OFS_REV) rd_d = DW'(REV_ID);
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (blk == BLK_W'(i + 1)) begin
                        case (sub)
                            CR_CFG:    rd_d = {{(DW-1){1'b0}}, ch_en[i]};
                            CR_RELOAD: rd_d = ch_reload[i];
                            CR_VALUE:  rd_d = ch_snap[i];
                            CR_OVF:    rd_d = ch_ovf[i];
                            CR_STAT:   rd_d = {{(DW-1){1'b0}}, ch_stat[i]};
                            CR_MASK:   rd_d = {{(DW-1){1'b0}}, ch_mask[i]};
                            default:   rd_d = '0;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tmrbank_top.sv
module tmrbank_top
    import tmrbank_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          AW     = 8,
    parameter int          NUM_CH = 4,
    parameter logic [31:0] REV_ID = 32'h0002_0001,
    localparam int         BLK_W  = AW - 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_tick,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    logic             gctrl_wr;
    logic             rd_en;
    logic [BLK_W-1:0] blk;
    logic [4:0]       sub;
    ch_acc_t          acc [NUM_CH];
    logic             gen_q;
    logic [DW-1:0]    rd_d;

    logic             ch_en     [NUM_CH];
    logic [DW-1:0]    ch_reload [NUM_CH];
    logic [DW-1:0]    ch_snap   [NUM_CH];
    logic [DW-1:0]    ch_ovf    [NUM_CH];
    logic             ch_stat   [NUM_CH];
    logic             ch_mask   [NUM_CH];
    logic [NUM_CH-1:0] stat_vec;
    logic [NUM_CH-1:0] mask_vec;

    tmrbank_decode #(.AW(AW), .NUM_CH(NUM_CH)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .gctrl_wr (gctrl_wr),
        .rd_en    (rd_en),
        .blk      (blk),
        .sub      (sub),
        .acc_o    (acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gen_q <= 1'b0;
        else if (gctrl_wr) gen_q <= bus_wdata[0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmrbank_chan #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_en  (gen_q),
            .tick     (cnt_tick),
            .acc      (acc[i]),
            .wdata    (bus_wdata),
            .en_o     (ch_en[i]),
            .reload_o (ch_reload[i]),
            .snap_o   (ch_snap[i]),
            .ovf_o    (ch_ovf[i]),
            .stat_o   (ch_stat[i]),
            .mask_o   (ch_mask[i])
        );
        assign stat_vec[i] = ch_stat[i];
        assign mask_vec[i] = ch_mask[i];
    end

    tmrbank_rdmux #(
        .DW(DW), .NUM_CH(NUM_CH), .BLK_W(BLK_W), .REV_ID(REV_ID)
    ) u_rdmux (
        .rd_en     (rd_en),
        .blk       (blk),
        .sub       (sub),
        .gen_q     (gen_q),
        .ch_en     (ch_en),
        .ch_reload (ch_reload),
        .ch_snap   (ch_snap),
        .ch_ovf    (ch_ovf),
        .ch_stat   (ch_stat),
        .ch_mask   (ch_mask),
        .rd_d      (rd_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_d;
    end

    assign irq_o = |(stat_vec & mask_vec);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|stat_vec));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (bus_rdata == '0));

endmodule

// File: tb/tmrbank_top_test.sv
module tmrbank_top_test;

    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [31:0] REV = 32'h0002_0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_tick = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] ovf_exp [4];

    always #5 clk = ~clk;

    tmrbank_top #(.DW(DW), .AW(AW), .NUM_CH(4), .REV_ID(REV)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [AW-1:0] ra(int ch, int ofs);
        return AW'(32'h20 + 32'h20 * ch + ofs);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(int n);
        if (n > 0) begin
            @(negedge clk);
            cnt_tick = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            cnt_tick = 1'b0;
        end
    endtask

    task automatic arm(int ch, logic [31:0] rl);
        wr(ra(ch, 'h00), 0);
        wr(ra(ch, 'h04), rl);
        wr(ra(ch, 'h14), 1);
        wr(ra(ch, 'h00), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < 4; c++) ovf_exp[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 0);
        rd(8'h00, d); chk("R1 gctrl", d, 0);
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o <= 'h18; o += 4) begin
                rd(ra(c, o), d); chk("R1 timer reg", d, 0);
            end
        end

        // R9 revision, unmapped, misaligned, ignored write
        rd(8'h10, d); chk("R9 rev", d, REV);
        rd(8'h04, d); chk("R9 unmapped 04", d, 0);
        rd(8'h3C, d); chk("R9 unmapped 3C", d, 0);
        rd(8'hA0, d); chk("R9 unmapped A0", d, 0);
        wr(8'h22, 1);
        rd(8'h20, d); chk("R9 misaligned write ignored", d, 0);
        wr(8'h10, 32'h55);
        rd(8'h10, d); chk("R9 rev read-only", d, REV);

        // R2 global gate
        arm(0, 10);
        ticks(5);
        rd(ra(0, 'h0C), d); chk("R2 ovf gated", d, 0);
        rd(ra(0, 'h08), d); chk("R2 value gated", d, 10);
        wr(8'h00, 1);
        rd(8'h00, d); chk("R2 gctrl readback", d, 1);
        ticks(3);
        rd(ra(0, 'h0C), d); chk("R2 ovf after enable", d, 0);
        rd(ra(0, 'h08), d); chk("R2 value after enable", d, 7);

        // R4 snapshot only follows wrap-count reads
        arm(0, 20);
        ticks(4);
        rd(ra(0, 'h0C), d);
        ticks(3);
        rd(ra(0, 'h08), d); chk("R4 snapshot held", d, 16);
        rd(ra(0, 'h0C), d); chk("R6 ovf pair", d, 0);
        rd(ra(0, 'h08), d); chk("R4 snapshot refreshed", d, 13);

        // R3 local disable stops counting
        arm(2, 9);
        ticks(2);
        wr(ra(2, 'h00), 0);
        ticks(4);
        rd(ra(2, 'h00), d); chk("R3 cfg readback", d, 0);
        rd(ra(2, 'h0C), d); chk("R3 ovf", d, 0);
        rd(ra(2, 'h08), d); chk("R3 value held", d, 7);

        // R5/R6/R10 sweep
        for (int c = 0; c < 4; c++) begin
            for (int rl = 0; rl < 4; rl++) begin
                for (int k = 0; k < 10; k++) begin
                    int wraps;
                    wraps = k / (rl + 1);
                    arm(c, rl);
                    ticks(k);
                    ovf_exp[c] = ovf_exp[c] + wraps;
                    rd(ra(c, 'h0C), d); chk("R5 R6 sweep ovf", d, ovf_exp[c]);
                    rd(ra(c, 'h08), d); chk("R5 sweep value", d, rl - (k % (rl + 1)));
                    rd(ra(c, 'h10), d); chk("R5 sweep status", d, (wraps > 0) ? 1 : 0);
                    wr(ra(c, 'h00), 0);
                end
            end
            for (int o = 0; o < 4; o++) begin
                if (o != c) begin
                    rd(ra(o, 'h0C), d); chk("R10 other timer ovf", d, ovf_exp[o]);
                end
            end
        end

        // R7 clear, set wins, clear reads zero
        arm(1, 0);
        ticks(1);
        ovf_exp[1] = ovf_exp[1] + 1;
        rd(ra(1, 'h10), d); chk("R7 status set", d, 1);
        @(negedge clk);
        cnt_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = ra(1, 'h14); bus_wdata = 1;
        @(negedge clk);
        cnt_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        ovf_exp[1] = ovf_exp[1] + 1;
        rd(ra(1, 'h10), d); chk("R7 set wins", d, 1);
        wr(ra(1, 'h14), 1);
        rd(ra(1, 'h10), d); chk("R7 cleared", d, 0);
        rd(ra(1, 'h14), d); chk("R7 clear reads zero", d, 0);
        rd(ra(1, 'h0C), d); chk("R5 ovf after clear test", d, ovf_exp[1]);
        wr(ra(1, 'h00), 0);

        // R8 interrupt masking
        arm(3, 0);
        ticks(1);
        ovf_exp[3] = ovf_exp[3] + 1;
        wr(ra(3, 'h00), 0);
        chk("R8 masked irq low", {31'b0, irq_o}, 0);
        wr(ra(3, 'h18), 1);
        chk("R8 unmasked irq high", {31'b0, irq_o}, 1);
        rd(ra(3, 'h18), d); chk("R8 mask readback", d, 1);
        wr(ra(3, 'h14), 1);
        chk("R8 irq after clear", {31'b0, irq_o}, 0);

        // R11 full-range free run
        arm(1, 32'hFFFF_FFFF);
        ticks(5);
        rd(ra(1, 'h0C), d); chk("R11 ovf", d, ovf_exp[1]);
        rd(ra(1, 'h08), d); chk("R11 elapsed", ~d, 5);
        rd(ra(1, 'h04), d); chk("R3 reload readback", d, 32'hFFFF_FFFF);

        finish_run();
    end

endmodule